// File: doc/BRIEF.md
# Tape Write Byte Transmitter

This block feeds one record of bytes onto the write-data side of a nine-track tape bus. An upstream source offers bytes through a valid/ready handshake and flags the final byte of the record. The transmitter places each byte on eight data lines and one parity line. Line 0 carries the most significant bit, and every line is active-low. The drive paces the record with its write strobe: each time the strobe is released, the next byte goes onto the bus.

A record begins with a one-cycle request on `rec_start`. The block takes the first byte and then pulls the write line and the start line low together. The start line stays low for a programmable number of cycles, and the write line stays low for the rest of the record. When the final byte is loaded, the last-word line goes low at once. The block also counts how long that line has been low before the drive's last strobe ends, and it raises an error flag if the lead time was too short. If the drive strobes while the source has no byte ready, the record ends with an underrun flag.

Top module: `tape_write_xmit`

## Requirements
- R1: While a byte is loaded, data line `wd_n[i]` carries the inverse of input bit `7-i`. Line 0 is the MSB and line 7 is the LSB. A logic one is driven as 0.
- R2: While a byte is loaded, `wp_n` is driven low exactly when the eight data bits hold an even number of ones. The parity bit is odd, driven active-low.
- R3: After reset and while no record is in progress, the following are all 1: `wd_n`, `wp_n`, `wrt_n`, `go_n` and `lwd_n`. `in_ready`, `done` and both error flags are 0.
- R4: After `rec_start`, `in_ready` is high until the first byte is accepted. In the cycle after acceptance, `go_n` goes low for exactly `GO_CYCLES` cycles, and `wrt_n` is low during that time.
- R5: `wrt_n` stays low from the start pulse until the record ends.
- R6: A rising edge of `wstr_n` (the strobe's trailing edge) is seen after `SYNC_STAGES` clocks. In that cycle, if the loaded byte is not the final one, `in_ready` is high and the offered byte is placed on the bus at the next clock. At any other time during a record, `in_ready` is low.
- R7: `lwd_n` goes low in the same clock that places the final byte on the bus. It stays low until the record ends.
- R8: The trailing strobe edge of the final byte ends the record. `done` is high for one cycle, and every bus line is released high in that same cycle.
- R9: A strobe trailing edge that finds a non-final byte loaded and `in_valid` low sets `err_underrun` and ends the record as in R8.
- R10: `err_lead` is set at the end of a record if, when the final strobe edge is detected, `lwd_n` has been low for fewer than `LWD_CYCLES` clocks. Both error flags clear on the next `rec_start`.
- R11: Strobe activity outside a record changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_start | input | 1 | One-cycle request to begin a record |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| in_data | input | 8 | Offered byte |
| in_last | input | 1 | Offered byte is the record's final byte |
| wstr_n | input | 1 | Drive write strobe, active low, asynchronous |
| wd_n | output | 8 | Write data lines, active low, line 0 = MSB |
| wp_n | output | 1 | Write parity line, odd parity, active low |
| wrt_n | output | 1 | Write command line, active low |
| go_n | output | 1 | Start pulse, active low |
| lwd_n | output | 1 | Last-word line, active low |
| done | output | 1 | One-cycle record end |
| err_underrun | output | 1 | Record ended for lack of data |
| err_lead | output | 1 | Last-word lead time was short |

## Verification
The embedded properties check several rules on every clock:
- the parity rule holds across the nine lines whenever a byte is loaded;
- the start pulse never appears without the write line;
- an accepted byte always leaves the write line low in the next cycle;
- the last-word line stays low until the record ends;
- `done` lasts one cycle and leaves the bus released;
- an underrun always coincides with a record end.

Only the bench scenarios can show the remaining behaviour:
- the exact MSB-first line mapping for chosen bytes;
- the cycle in which a byte follows a strobe edge;
- the exact length of the start pulse;
- whether a short last-word lead is flagged, depending on the gap before the final strobe;
- that strobes outside a record leave the outputs untouched.

// File: rtl/twx_pkg.sv
package twx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_GO,
        ST_XFER,
        ST_FIN
    } twx_state_e;

    // Nine bus lines for one byte, already in active-low form.
    typedef struct packed {
        logic [7:0] data_n;
        logic       par_n;
    } twx_lane_t;

    localparam twx_lane_t LANE_RELEASED = '{data_n: 8'hFF, par_n: 1'b1};

    // Line i carries bit 7-i. The bus inverts every line. The odd parity bit is
    // the complement of the XOR, so its inverted form is the XOR itself.
    function automatic twx_lane_t encode_lane(input logic [7:0] b);
        twx_lane_t l;
        for (int i = 0; i < 8; i++) begin
            l.data_n[i] = ~b[7-i];
        end
        l.par_n = ^b;
        return l;
    endfunction

endpackage

// File: rtl/twx_sync_edge.sv
module twx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/twx_pulse_timer.sv
module twx_pulse_timer #(
    parameter int LEN = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic expire
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == CW'(LEN - 1)) active <= 1'b0;
            else                     cnt    <= cnt + 1'b1;
        end
    end

    assign expire = active && (cnt == CW'(LEN - 1));

endmodule

// File: rtl/twx_lead_counter.sv
module twx_lead_counter #(
    parameter int LEAD = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic met
);
    localparam int CW = $clog2(LEAD + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)            cnt <= '0;
        else if (cnt != CW'(LEAD))   cnt <= cnt + 1'b1;
    end

    assign met = (cnt == CW'(LEAD));

endmodule

// File: rtl/twx_lane_reg.sv
module twx_lane_reg
    import twx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       clear,
    input  logic [7:0] byte_in,
    input  logic       last_in,
    output twx_lane_t  lane,
    output logic       last,
    output logic       loaded
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lane   <= LANE_RELEASED;
            last   <= 1'b0;
            loaded <= 1'b0;
        end else if (load) begin
            lane   <= encode_lane(byte_in);
            last   <= last_in;
            loaded <= 1'b1;
        end
    end

    // Nine lines together hold an odd number of asserted (low) lines.
    AST_PARITY_ODD: assert property (@(posedge clk) disable iff (rst)
        loaded |-> ($countones(~{lane.data_n, lane.par_n}) % 2 == 1)); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !loaded |-> (lane == LANE_RELEASED)); // R3

endmodule

// File: rtl/tape_write_xmit.sv
module tape_write_xmit
    import twx_pkg::*;
#(
    parameter int GO_CYCLES   = 100,
    parameter int LWD_CYCLES  = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rec_start,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       wstr_n,
    output logic [7:0] wd_n,
    output logic       wp_n,
    output logic       wrt_n,
    output logic       go_n,
    output logic       lwd_n,
    output logic       done,
    output logic       err_underrun,
    output logic       err_lead
);
    twx_state_e state;
    twx_lane_t  lane;
    logic       lane_last, lane_loaded;
    logic       trail, go_active, go_expire, lead_met;
    logic       lane_load, lane_clear, go_start, lead_clear;

    twx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(wstr_n), .rise(trail)
    );

    assign go_start   = (state == ST_LOAD) && in_valid;
    assign lane_load  = go_start ||
                        ((state == ST_XFER) && trail && !lane_last && in_valid);
    assign lane_clear = (state == ST_XFER) && trail && (lane_last || !in_valid);
    assign lead_clear = lane_load && in_last;
    assign in_ready   = (state == ST_LOAD) ||
                        ((state == ST_XFER) && trail && !lane_last);

    twx_pulse_timer #(.LEN(GO_CYCLES)) u_go (
        .clk(clk), .rst(rst), .start(go_start),
        .active(go_active), .expire(go_expire)
    );

    twx_lead_counter #(.LEAD(LWD_CYCLES)) u_lead (
        .clk(clk), .rst(rst), .clear(lead_clear), .met(lead_met)
    );

    twx_lane_reg u_lane (
        .clk(clk), .rst(rst), .load(lane_load), .clear(lane_clear),
        .byte_in(in_data), .last_in(in_last),
        .lane(lane), .last(lane_last), .loaded(lane_loaded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            err_underrun <= 1'b0;
            err_lead     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (rec_start) begin
                    state        <= ST_LOAD;
                    err_underrun <= 1'b0;
                    err_lead     <= 1'b0;
                end
                ST_LOAD: if (in_valid) state <= ST_GO;
                ST_GO:   if (go_expire) state <= ST_XFER;
                ST_XFER: if (trail) begin
                    if (lane_last) begin
                        state    <= ST_FIN;
                        err_lead <= !lead_met;
                    end else if (!in_valid) begin
                        state        <= ST_FIN;
                        err_underrun <= 1'b1;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wd_n  = lane.data_n;
    assign wp_n  = lane.par_n;
    assign go_n  = ~go_active;
    assign wrt_n = ~((state == ST_GO) || (state == ST_XFER));
    assign lwd_n = ~(lane_loaded && lane_last);
    assign done  = (state == ST_FIN);

    AST_GO_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        !go_n |-> !wrt_n); // R4

    AST_ACCEPT_KEEPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |=> !wrt_n); // R5

    AST_LAST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (!lwd_n && !done) |=> (!lwd_n || done)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        done |-> (wd_n == 8'hFF && wp_n && lwd_n && wrt_n && go_n)); // R8

    AST_UNDERRUN_ENDS: assert property (@(posedge clk) disable iff (rst)
        $rose(err_underrun) |-> done); // R9

    AST_READY_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wrt_n && go_n && !in_ready) |=> (!in_ready || !$stable(state) || rec_start || $past(rec_start))); // R11

endmodule

// File: tb/tape_write_xmit_tb.sv
module tape_write_xmit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int GO_N       = 4;
    localparam int LEAD_N     = 6;

    // {data[12:5], last[4], gap before the strobe that ends this byte[3:0]}
    localparam logic [12:0] VEC [8] = '{
        {8'hA5, 1'b0, 4'd1},
        {8'h01, 1'b0, 4'd2},
        {8'hFF, 1'b1, 4'd2},
        {8'h00, 1'b1, 4'd3},
        {8'h80, 1'b0, 4'd0},
        {8'h7E, 1'b0, 4'd1},
        {8'h3C, 1'b1, 4'd0},
        {8'hC3, 1'b1, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rec_start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       wstr_n = 1'b1;
    logic [7:0] wd_n;
    logic       wp_n, wrt_n, go_n, lwd_n, done, err_underrun, err_lead;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tape_write_xmit #(.GO_CYCLES(GO_N), .LWD_CYCLES(LEAD_N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .rec_start(rec_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .wstr_n(wstr_n), .wd_n(wd_n), .wp_n(wp_n), .wrt_n(wrt_n), .go_n(go_n),
        .lwd_n(lwd_n), .done(done), .err_underrun(err_underrun), .err_lead(err_lead)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_data_n(input logic [7:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ~d[7-i];
        return r;
    endfunction

    function automatic logic exp_par_n(input logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        return (ones % 2 == 0) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk_idle(input string req);
        chk({req, " data"}, {24'h0, wd_n}, 32'hFF);
        chk({req, " lines"}, {27'h0, wp_n, wrt_n, go_n, lwd_n, in_ready},
            {27'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
    endtask

    task automatic start_record(input logic [7:0] d, input logic l);
        in_data = d; in_last = l; in_valid = 1'b1; rec_start = 1'b1;
        @(negedge clk);
        rec_start = 1'b0;
        chk("R4 ready while waiting for first byte", {31'h0, in_ready}, 32'h1);
        @(negedge clk);
        chk("R1 first byte lines", {24'h0, wd_n}, {24'h0, exp_data_n(d)});
        chk("R2 first byte parity", {31'h0, wp_n}, {31'h0, exp_par_n(d)});
        chk("R4 start pulse with write", {30'h0, go_n, wrt_n}, 32'h0);
        chk("R7 last word on first byte", {31'h0, lwd_n}, {31'h0, ~l});
        repeat (GO_N) @(negedge clk);
        chk("R4 start pulse length / R5 write held", {30'h0, go_n, wrt_n}, 32'h2);
    endtask

    // Strobe low for three cycles, then release; returns after the reload clock.
    task automatic do_strobe(input logic exp_ready, input string req);
        wstr_n = 1'b0;
        repeat (3) @(negedge clk);
        wstr_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(req, {31'h0, in_ready}, {31'h0, exp_ready});
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic prev_last;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R3 reset state");
        chk("R3 flags after reset", {29'h0, done, err_underrun, err_lead}, 32'h0);

        // Stimulus table walked record by record.
        prev_last = 1'b1;
        for (int e = 0; e < 8; e++) begin
            logic [7:0] d;
            logic       l, first, lead_bad;
            int         g;
            d = VEC[e][12:5];
            l = VEC[e][4];
            g = int'(VEC[e][3:0]);
            first = prev_last;
            if (first) start_record(d, l);
            if (!l) begin
                in_data  = VEC[e+1][12:5];
                in_last  = VEC[e+1][4];
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
            repeat (g) @(negedge clk);
            do_strobe(!l, "R6 ready only on strobe edge of non-final byte");
            if (l) begin
                lead_bad = !first && (g + 5 < LEAD_N);
                chk("R8 done pulse", {31'h0, done}, 32'h1);
                chk_idle("R8 lines released");
                chk("R10 lead flag", {31'h0, err_lead}, {31'h0, lead_bad});
                chk("R9 no underrun", {31'h0, err_underrun}, 32'h0);
                @(negedge clk);
                chk("R8 done single cycle", {31'h0, done}, 32'h0);
            end else begin
                chk("R1 next byte lines", {24'h0, wd_n}, {24'h0, exp_data_n(VEC[e+1][12:5])});
                chk("R2 next byte parity", {31'h0, wp_n}, {31'h0, exp_par_n(VEC[e+1][12:5])});
                chk("R7 last word follows load", {31'h0, lwd_n}, {31'h0, ~VEC[e+1][4]});
                chk("R5 write held mid record", {31'h0, wrt_n}, 32'h0);
            end
            prev_last = l;
        end

        // R10: flags clear on the next start.
        start_record(8'h5A, 1'b0);
        chk("R10 flags cleared by start", {30'h0, err_underrun, err_lead}, 32'h0);

        // R9: underrun on a strobe with no byte offered.
        in_valid = 1'b0;
        do_strobe(1'b1, "R6 ready on edge during underrun");
        chk("R9 underrun flag", {31'h0, err_underrun}, 32'h1);
        chk("R9 record ends", {31'h0, done}, 32'h1);
        chk_idle("R9 lines released");
        @(negedge clk);

        // R11: strobes while idle change nothing.
        do_strobe(1'b0, "R11 no ready while idle");
        chk_idle("R11 idle lines after strobe");
        chk("R11 no done while idle", {31'h0, done}, 32'h0);
        repeat (3) @(negedge clk);
        chk_idle("R11 idle lines later");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule